// File: doc/BRIEF.md
# DMA Page Extension Unit

This unit sits next to a four-channel DMA controller whose own address counter is only 16 bits wide. It holds, for each channel, an 8-bit page value, a 7-bit high-page value and an 8-bit boundary mask. It also holds one global 8-bit access-control value. From these it builds the 31-bit physical address of the channel currently being served. When access-control bit 2 is set, that address is confined to a 1 MiB window.

When the controller finishes a block, it pulses `done_valid` together with the channel number and the carry (or borrow) bit that its 16-bit address produced. If that bit is set and the channel's mask is nonzero, the unit steps the channel's page up or down. Only the page bits selected by the mask take part in the step. A host programs the registers through a byte-wide port that has an address, a write strobe and a read strobe.

Top module: `dma_page_ext`

## Requirements
- R1: With access-control bit 2 clear, `phys_addr` is {high-page[6:0], page[7:0], `cur_addr`[15:0]} of the channel on `cur_chan`, formed combinationally.
- R2: With access-control bit 2 set, `phys_addr` bits 30:20 are forced to zero and bits 19:0 are unchanged.
- R3: A clock edge with `rst` high clears every page, high-page and mask register to 0x00 and loads access control with 0xB4.
- R4: A write to address 9 loads access control. A read with `rd_en` high at address 9 returns it in the same cycle. `rd_data` is 0x00 while `rd_en` is low.
- R5: Reads at any address other than 9 return 0xFF. This includes the write-only page (0 to 3), high-page (4 to 7) and boundary (8) addresses.
- R6: A write to page slot s (address s, 0 to 3) loads the page of channel (s+1) mod 4.
- R7: A write to high-page slot s (address 4+s) loads bits 6:0 of the data into the high page of channel (s+2) mod 4. Data bit 7 is dropped.
- R8: A write to address 8 picks the channel from data bits 1:0 and loads its mask from data bits 3:2. Code 0 gives 0x00, code 1 gives 0x0F, code 2 gives 0x00 and code 3 gives 0xFF.
- R9: On a `done_valid` cycle with `done_carry` set, a nonzero mask and that channel's `dir_down` bit clear, the page becomes ((page+1) & mask) | (page & ~mask) after the next edge.
- R10: Under the same conditions but with the `dir_down` bit set, the page becomes ((page-1) & mask) | (page & ~mask).
- R11: A `done_valid` pulse with `done_carry` clear, or aimed at a channel whose mask is zero, leaves every page unchanged.
- R12: If a host write to a channel's page and a step of that same page fall in the same cycle, the host write value is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 4 | Host register address |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | 8 | Host write data |
| rd_en | input | 1 | Host read strobe |
| rd_data | output | 8 | Host read data (combinational) |
| dir_down | input | 4 | Per-channel direction: 1 means the address decrements |
| cur_chan | input | 2 | Channel currently served |
| cur_addr | input | 16 | Controller's current 16-bit address |
| done_valid | input | 1 | Block-done pulse |
| done_chan | input | 2 | Channel that finished the block |
| done_carry | input | 1 | Bit 16 of the final address (carry or borrow out) |
| phys_addr | output | 31 | Physical transfer address |

## Verification
The assertions assume that `done_chan` names a real channel on every `done_valid` cycle. They also assume that host strobes and done pulses last exactly one clock, so that the state before and after a single edge can be compared. The stability property for ignored block-done pulses only holds when no host write occurs in the same cycle. For that reason the stimulus keeps done pulses apart from writes, except in the one deliberate collision case. The stimulus changes every input a quarter period after the rising edge, so the reference model and the design sample identical values.

// File: rtl/dma_page_pkg.sv
package dma_page_pkg;
    localparam int NCHAN   = 4;
    localparam int CHW     = $clog2(NCHAN);
    localparam int PAGE_W  = 8;
    localparam int HPAGE_W = 7;
    localparam int OFF_W   = 16;
    localparam int WIN_W   = 20;
    localparam int REG_AW  = 4;
    localparam int DATA_W  = 8;
    localparam int PHYS_W  = HPAGE_W + PAGE_W + OFF_W;

    localparam logic [REG_AW-1:0] ADDR_HPAGE0 = 4'd4;
    localparam logic [REG_AW-1:0] ADDR_BOUND  = 4'd8;
    localparam logic [REG_AW-1:0] ADDR_ACC    = 4'd9;
    localparam logic [DATA_W-1:0] ACC_RESET   = 8'hB4;
    localparam int                TRUNC_BIT   = 2;

    typedef enum logic [2:0] {
        K_PAGE, K_HPAGE, K_BOUND, K_ACC, K_NONE
    } reg_kind_e;

    typedef logic [NCHAN-1:0][PAGE_W-1:0]  page_arr_t;
    typedef logic [NCHAN-1:0][HPAGE_W-1:0] hpage_arr_t;

    function automatic reg_kind_e reg_kind(input logic [REG_AW-1:0] a);
        if (a < ADDR_HPAGE0)      return K_PAGE;
        else if (a < ADDR_BOUND)  return K_HPAGE;
        else if (a == ADDR_BOUND) return K_BOUND;
        else if (a == ADDR_ACC)   return K_ACC;
        else                      return K_NONE;
    endfunction

    function automatic logic [PAGE_W-1:0] bound_decode(input logic [1:0] code);
        case (code)
            2'd1:    return 8'h0F;
            2'd3:    return 8'hFF;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [PAGE_W-1:0] page_step(input logic [PAGE_W-1:0] pg,
                                                     input logic [PAGE_W-1:0] msk,
                                                     input logic down);
        logic [PAGE_W-1:0] nxt;
        nxt = down ? pg - 1'b1 : pg + 1'b1;
        return (nxt & msk) | (pg & ~msk);
    endfunction

    function automatic logic [CHW-1:0] page_slot_chan(input logic [CHW-1:0] s);
        return s + CHW'(1);
    endfunction

    function automatic logic [CHW-1:0] hpage_slot_chan(input logic [CHW-1:0] s);
        return s - CHW'(2);
    endfunction
endpackage

// File: rtl/dma_page_decode.sv
module dma_page_decode
    import dma_page_pkg::*;
(
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              wr_en,
    input  logic [CHW-1:0]    bound_sel,
    output logic [NCHAN-1:0]  page_we,
    output logic [NCHAN-1:0]  hpage_we,
    output logic [NCHAN-1:0]  bound_we,
    output logic              acc_we
);
    reg_kind_e      kind;
    logic [CHW-1:0] slot;

    always_comb begin
        kind     = reg_kind(reg_addr);
        slot     = reg_addr[CHW-1:0];
        page_we  = '0;
        hpage_we = '0;
        bound_we = '0;
        acc_we   = 1'b0;
        if (wr_en) begin
            case (kind)
                K_PAGE:  page_we[page_slot_chan(slot)]   = 1'b1;
                K_HPAGE: hpage_we[hpage_slot_chan(slot)] = 1'b1;
                K_BOUND: bound_we[bound_sel]             = 1'b1;
                K_ACC:   acc_we                          = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/dma_page_chan.sv
module dma_page_chan
    import dma_page_pkg::*;
#(
    parameter int IDX = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               page_we,
    input  logic               hpage_we,
    input  logic               bound_we,
    input  logic [PAGE_W-1:0]  wr_data,
    input  logic [1:0]         bound_code,
    input  logic               done_valid,
    input  logic [CHW-1:0]     done_chan,
    input  logic               done_carry,
    input  logic               dir_down,
    output logic [PAGE_W-1:0]  page,
    output logic [HPAGE_W-1:0] hpage,
    output logic [PAGE_W-1:0]  mask
);
    logic step_en;

    assign step_en = done_valid && (done_chan == CHW'(IDX)) && done_carry && (mask != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            page  <= '0;
            hpage <= '0;
            mask  <= '0;
        end else begin
            if (bound_we) mask  <= bound_decode(bound_code);
            if (hpage_we) hpage <= wr_data[HPAGE_W-1:0];
            if (page_we)      page <= wr_data;
            else if (step_en) page <= page_step(page, mask, dir_down);
        end
    end
endmodule

// File: rtl/dma_page_addr.sv
module dma_page_addr
    import dma_page_pkg::*;
(
    input  page_arr_t          pages,
    input  hpage_arr_t         hpages,
    input  logic [CHW-1:0]     cur_chan,
    input  logic [OFF_W-1:0]   cur_addr,
    input  logic               trunc,
    output logic [PHYS_W-1:0]  phys_addr
);
    localparam logic [PHYS_W-1:0] WIN_MASK = {{(PHYS_W-WIN_W){1'b0}}, {WIN_W{1'b1}}};

    logic [PHYS_W-1:0] full;

    always_comb begin
        full      = {hpages[cur_chan], pages[cur_chan], cur_addr};
        phys_addr = trunc ? (full & WIN_MASK) : full;
    end
endmodule

// File: rtl/dma_page_ext.sv
module dma_page_ext
    import dma_page_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [REG_AW-1:0]      reg_addr,
    input  logic                   wr_en,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   rd_en,
    output logic [DATA_W-1:0]      rd_data,
    input  logic [NCHAN-1:0]       dir_down,
    input  logic [CHW-1:0]         cur_chan,
    input  logic [OFF_W-1:0]       cur_addr,
    input  logic                   done_valid,
    input  logic [CHW-1:0]         done_chan,
    input  logic                   done_carry,
    output logic [PHYS_W-1:0]      phys_addr
);
    logic [NCHAN-1:0] page_we, hpage_we, bound_we;
    logic             acc_we;
    logic [DATA_W-1:0] acc_q;
    page_arr_t        page_q;
    page_arr_t        mask_q;
    hpage_arr_t       hpage_q;

    dma_page_decode u_dec (
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .bound_sel(wr_data[CHW-1:0]),
        .page_we  (page_we),
        .hpage_we (hpage_we),
        .bound_we (bound_we),
        .acc_we   (acc_we)
    );

    for (genvar c = 0; c < NCHAN; c++) begin : g_chan
        dma_page_chan #(.IDX(c)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .page_we   (page_we[c]),
            .hpage_we  (hpage_we[c]),
            .bound_we  (bound_we[c]),
            .wr_data   (wr_data),
            .bound_code(wr_data[3:2]),
            .done_valid(done_valid),
            .done_chan (done_chan),
            .done_carry(done_carry),
            .dir_down  (dir_down[c]),
            .page      (page_q[c]),
            .hpage     (hpage_q[c]),
            .mask      (mask_q[c])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)         acc_q <= ACC_RESET;
        else if (acc_we) acc_q <= wr_data;
    end

    always_comb begin
        if (!rd_en)                          rd_data = '0;
        else if (reg_kind(reg_addr) == K_ACC) rd_data = acc_q;
        else                                 rd_data = '1;
    end

    dma_page_addr u_addr (
        .pages    (page_q),
        .hpages   (hpage_q),
        .cur_chan (cur_chan),
        .cur_addr (cur_addr),
        .trunc    (acc_q[TRUNC_BIT]),
        .phys_addr(phys_addr)
    );
endmodule

// File: rtl/dma_page_ext_chk.sv
module dma_page_ext_chk
    import dma_page_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic [REG_AW-1:0]   reg_addr,
    input logic                wr_en,
    input logic [DATA_W-1:0]   wr_data,
    input logic                rd_en,
    input logic [DATA_W-1:0]   rd_data,
    input logic [DATA_W-1:0]   acc_q,
    input page_arr_t           pages,
    input page_arr_t           masks,
    input logic                done_valid,
    input logic [CHW-1:0]      done_chan,
    input logic                done_carry,
    input logic [OFF_W-1:0]    cur_addr,
    input logic [PHYS_W-1:0]   phys_addr
);
    assert_low_offset_R1: assert property (@(posedge clk) disable iff (rst)
        phys_addr[OFF_W-1:0] == cur_addr);

    assert_window_R2: assert property (@(posedge clk) disable iff (rst)
        acc_q[TRUNC_BIT] |-> phys_addr[PHYS_W-1:WIN_W] == '0);

    assert_acc_load_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && reg_addr == ADDR_ACC) |=> acc_q == $past(wr_data));

    assert_wo_read_R5: assert property (@(posedge clk) disable iff (rst)
        (rd_en && reg_addr != ADDR_ACC) |-> rd_data == 8'hFF);

    assert_step_moves_R9: assert property (@(posedge clk) disable iff (rst)
        (done_valid && done_carry && masks[done_chan] != '0 && !wr_en)
        |=> pages[$past(done_chan)] != $past(pages[done_chan]));

    assert_no_step_R11: assert property (@(posedge clk) disable iff (rst)
        (done_valid && (!done_carry || masks[done_chan] == '0) && !wr_en)
        |=> $stable(pages));
endmodule

bind dma_page_ext dma_page_ext_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .acc_q     (acc_q),
    .pages     (page_q),
    .masks     (mask_q),
    .done_valid(done_valid),
    .done_chan (done_chan),
    .done_carry(done_carry),
    .cur_addr  (cur_addr),
    .phys_addr (phys_addr)
);

// File: tb/dma_page_ext_test.sv
module dma_page_ext_test;
    localparam int CLK_PERIOD = 10;
    localparam int Q = CLK_PERIOD / 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [3:0]  reg_addr = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_data;
    logic [3:0]  dir_down = 4'b0010;
    logic [1:0]  cur_chan = '0;
    logic [15:0] cur_addr = '0;
    logic        done_valid = 1'b0;
    logic [1:0]  done_chan = '0;
    logic        done_carry = 1'b0;
    logic [30:0] phys_addr;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    int m_page[4];
    int m_hp[4];
    int m_mask[4];
    int m_acc;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_page_ext uut (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .wr_en(wr_en),
        .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .dir_down(dir_down), .cur_chan(cur_chan), .cur_addr(cur_addr),
        .done_valid(done_valid), .done_chan(done_chan),
        .done_carry(done_carry), .phys_addr(phys_addr)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic int mask_of(input int code);
        if (code == 1) return 'h0F;
        if (code == 3) return 'hFF;
        return 0;
    endfunction

    // reference model: behavioural register state
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                m_page[i] = 0; m_hp[i] = 0; m_mask[i] = 0;
            end
            m_acc = 'hB4;
        end else begin
            if (done_valid && done_carry && m_mask[done_chan] != 0) begin
                int p, n, mk;
                p  = m_page[done_chan];
                mk = m_mask[done_chan];
                n  = dir_down[done_chan] ? p - 1 : p + 1;
                m_page[done_chan] = ((n & mk) | (p & ~mk)) & 'hFF;
            end
            if (wr_en) begin
                if (reg_addr < 4)       m_page[(reg_addr + 1) % 4] = wr_data;
                else if (reg_addr < 8)  m_hp[(reg_addr - 4 + 2) % 4] = wr_data & 'h7F;
                else if (reg_addr == 8) m_mask[wr_data & 3] = mask_of((wr_data >> 2) & 3);
                else if (reg_addr == 9) m_acc = wr_data;
            end
        end
    end

    function automatic logic [31:0] model_phys();
        logic [31:0] a;
        a = (m_hp[cur_chan] << 24) | (m_page[cur_chan] << 16) | cur_addr;
        if (m_acc & 4) a = a & 32'hFFFFF;
        return a;
    endfunction

    function automatic logic [31:0] model_rd();
        if (!rd_en) return 0;
        if (reg_addr == 9) return m_acc;
        return 'hFF;
    endfunction

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R1 R2 per-cycle phys_addr", {1'b0, phys_addr}, model_phys());
            chk("R4 R5 per-cycle rd_data", {24'd0, rd_data}, model_rd());
        end
    end

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk); #Q;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [7:0] exp, input string tag);
        reg_addr = a; rd_en = 1'b1;
        #1 chk(tag, {24'd0, rd_data}, {24'd0, exp});
        rd_en = 1'b0;
    endtask

    task automatic ph(input logic [1:0] ch, input logic [15:0] a, input logic [31:0] exp, input string tag);
        cur_chan = ch; cur_addr = a;
        #1 chk(tag, {1'b0, phys_addr}, exp);
    endtask

    task automatic done(input logic [1:0] ch, input logic c);
        done_chan = ch; done_carry = c; done_valid = 1'b1;
        @(posedge clk); #Q;
        done_valid = 1'b0; done_carry = 1'b0;
    endtask

    task automatic finish_run();
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #Q rst = 1'b0;

        rd(4'd9, 8'hB4, "R3 access control reset value");
        ph(2'd0, 16'h1234, 32'h0001234, "R3 pages cleared by reset");

        wr(4'd9, 8'h00); rd(4'd9, 8'h00, "R4 access control write 00");
        wr(4'd9, 8'h5A); rd(4'd9, 8'h5A, "R4 access control write 5A");
        wr(4'd9, 8'h00);

        rd(4'd0, 8'hFF, "R5 page slot read");
        rd(4'd5, 8'hFF, "R5 high-page slot read");
        rd(4'd8, 8'hFF, "R5 boundary read");
        rd(4'd15, 8'hFF, "R5 unmapped read");

        wr(4'd0, 8'h11); wr(4'd1, 8'h22); wr(4'd2, 8'h33); wr(4'd3, 8'h44);
        ph(2'd0, 16'h0000, 32'h00440000, "R6 slot3 to chan0");
        ph(2'd1, 16'h0000, 32'h00110000, "R6 slot0 to chan1");
        ph(2'd2, 16'h0000, 32'h00220000, "R6 slot1 to chan2");
        ph(2'd3, 16'h0000, 32'h00330000, "R6 slot2 to chan3");

        wr(4'd4, 8'h81); wr(4'd5, 8'h02); wr(4'd6, 8'h03); wr(4'd7, 8'h04);
        ph(2'd0, 16'h1234, 32'h03441234, "R1 full address chan0");
        ph(2'd1, 16'h1234, 32'h04111234, "R7 slot3 to chan1");
        ph(2'd2, 16'h1234, 32'h01221234, "R7 slot0 to chan2 bit7 dropped");
        ph(2'd3, 16'hBEEF, 32'h0233BEEF, "R1 full address chan3");

        wr(4'd9, 8'h04);
        ph(2'd0, 16'h1234, 32'h00041234, "R2 window chan0");
        ph(2'd1, 16'hFFFF, 32'h0001FFFF, "R2 window chan1");
        wr(4'd9, 8'h00);

        done(2'd0, 1'b1);
        ph(2'd0, 16'h0000, 32'h03440000, "R11 zero mask ignores carry");

        wr(4'd8, 8'h04);
        done(2'd0, 1'b1);
        ph(2'd0, 16'h0000, 32'h03450000, "R9 step up within 0F mask");
        done(2'd0, 1'b0);
        ph(2'd0, 16'h0000, 32'h03450000, "R11 no carry no step");
        wr(4'd3, 8'h4F);
        done(2'd0, 1'b1);
        ph(2'd0, 16'h0000, 32'h03400000, "R9 wrap inside masked nibble");

        wr(4'd8, 8'h08);
        done(2'd0, 1'b1);
        ph(2'd0, 16'h0000, 32'h03400000, "R8 code 2 gives zero mask");

        wr(4'd8, 8'h0D);
        done(2'd1, 1'b1);
        ph(2'd1, 16'h0000, 32'h04100000, "R10 step down on borrow");
        wr(4'd0, 8'h00);
        done(2'd1, 1'b1);
        ph(2'd1, 16'h0000, 32'h04FF0000, "R10 borrow wraps full mask");

        reg_addr = 4'd0; wr_data = 8'h77; wr_en = 1'b1;
        done_chan = 2'd1; done_carry = 1'b1; done_valid = 1'b1;
        @(posedge clk); #Q;
        wr_en = 1'b0; done_valid = 1'b0; done_carry = 1'b0;
        ph(2'd1, 16'h0000, 32'h04770000, "R12 host write beats step");

        wr(4'd8, 8'h0E);
        done(2'd2, 1'b1);
        ph(2'd2, 16'h0000, 32'h01230000, "R8 code 3 gives FF mask");

        @(posedge clk); #Q;
        finish_run();
    end
endmodule